// File: doc/BRIEF.md
# Block-Merging Write Buffer

This block sits between a write-through data cache that never allocates on a store miss and the next cache level down. Every store the core issues, whether it hit or missed the first-level cache, enters here as one word with byte enables. The buffer keeps a small number of slots. Each slot holds one complete cache block, with a valid flag for every byte.

A store whose block address matches a slot that can still be modified is folded into that slot. This stitches runs of sequential stores into whole blocks, so that the next level can take one full-block write instead of many partial ones. A store that matches no such slot takes a fresh slot. When every slot is occupied and the store can neither merge nor reuse a slot being freed in the same cycle, the store is held off with a low ready.

Slots leave in the order they were filled, through a request/acknowledge drain port. That port shows the block address, the block data and the byte mask, and it flags whether the whole block is valid. The oldest slot is presented on that port as soon as it is occupied, and from then on it accepts no more merges.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the drain port shows no entry (`dr_valid` low) and a store is accepted at once (`st_ready` high). An empty buffer always accepts.
- R2: A store that matches no modifiable slot is accepted into a new slot. When that slot reaches the drain port, `dr_blk_addr` is `st_addr[31:5]`. The word `st_addr[4:2]` receives `st_wdata`: lane `l` of the word is byte `4*word + l` of the block, data bits `[8*byte +: 8]`, mask bit `byte`, and the lane is enabled by `st_be[l]`. Bytes that were never written read zero with mask bit 0. `st_addr[1:0]` is ignored.
- R3: A store whose block equals the block of an occupied slot other than the oldest merges into that slot. Its enabled bytes overwrite the earlier contents, its mask bits are ORed in, and no slot is allocated. This also holds when all slots are full.
- R4: The oldest occupied slot is locked. A store to its block allocates a new slot, or stalls if no slot is free, and leaves the locked slot unchanged.
- R5: With every slot occupied, a store that cannot merge sees `st_ready` low unless a drain completes in the same cycle. The stalled store does not enter the buffer.
- R6: In a cycle where `dr_valid` and `dr_ack` are both high, `st_ready` is high, and a non-merging store takes the slot being freed.
- R7: Slots drain oldest first, one per cycle in which `dr_valid` and `dr_ack` are both high.
- R8: `dr_full` is high exactly when all 32 byte-mask bits of the presented slot are set.
- R9: While `dr_valid` is high and `dr_ack` is low, the presented address, data and mask hold their values into the next cycle.
- R10: `dr_valid` is high whenever any slot is occupied, and it drops after the last slot is drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion synchronous to clk |
| st_valid | input | 1 | Store word offered |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| st_addr | input | 32 | Byte address of the store word |
| st_wdata | input | 32 | Store data, lane l in bits [8l+7:8l] |
| st_be | input | 4 | Per-lane byte enables |
| dr_valid | output | 1 | Oldest slot presented for draining |
| dr_ack | input | 1 | Next level takes the presented slot this cycle |
| dr_blk_addr | output | 27 | Block address of the presented slot |
| dr_data | output | 256 | Block data of the presented slot |
| dr_byte_mask | output | 32 | Valid bytes of the presented slot |
| dr_full | output | 1 | Presented slot is a complete block |

## Verification
The ready output and its stall decision are combinational in the same cycle as the offered store and the drain acknowledge. The bench therefore reads `st_ready` one nanosecond after it changes the inputs at a falling edge. Allocations, merges and drains take effect at the next rising edge, so the drain-port fields are compared at the falling edge that follows, one cycle after the accepting store or the acknowledge. The bench first sweeps every word position against every nonzero byte-enable pattern. It then runs directed sequences: stitching stores into a full block, a store to the locked block, stalls on a full buffer, and reuse of a slot in the same cycle it is drained. Each sequence builds its expected blocks byte by byte in the bench.

// File: rtl/wb_pkg.sv
`timescale 1ns/1ps
package wb_pkg;
  // What an offered store does to the slot array in the current cycle.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } st_act_e;
endpackage

// File: rtl/wb_order.sv
`timescale 1ns/1ps
// Circular occupancy tracker: oldest pointer, fill pointer, count.
module wb_order #(
  parameter int N_ENT = 4,
  localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head_idx,
  output logic [PTR_W-1:0] tail_idx,
  output logic [N_ENT-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             upd_en;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(N_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic in_window(input int idx, input int h, input int c);
    int d;
    d = (idx >= h) ? (idx - h) : (idx + N_ENT - h);
    return d < c;
  endfunction

  always_comb begin
    upd_en = push | pop;
    head_n = pop  ? wrap_inc(head_q) : head_q;
    tail_n = push ? wrap_inc(tail_q) : tail_q;
    cnt_n  = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_occ
    assign occ[i] = in_window(i, int'(head_q), int'(cnt_q));
  end

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign full     = (cnt_q == CNT_W'(N_ENT));
  assign empty    = (cnt_q == '0);
endmodule

// File: rtl/wb_match.sv
`timescale 1ns/1ps
// Parallel block-address compare against every mergeable slot.
module wb_match #(
  parameter int N_ENT = 4,
  parameter int BLK_W = 27
) (
  input  logic [BLK_W-1:0]            key,
  input  logic [N_ENT-1:0][BLK_W-1:0] tags,
  input  logic [N_ENT-1:0]            elig,
  output logic [N_ENT-1:0]            hit,
  output logic                        hit_any
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit[i] = elig[i] && (tags[i] == key);
  end
  assign hit_any = |hit;
endmodule

// File: rtl/wb_entry.sv
`timescale 1ns/1ps
// One block-sized slot: block address, data bytes, byte-valid mask.
module wb_entry #(
  parameter int BLK_W       = 27,
  parameter int BLOCK_BYTES = 32,
  localparam int BLOCK_BITS = BLOCK_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   merge,
  input  logic [BLK_W-1:0]       blk_in,
  input  logic [BLOCK_BITS-1:0]  wide_data,
  input  logic [BLOCK_BYTES-1:0] wide_mask,
  output logic [BLK_W-1:0]       blk_q,
  output logic [BLOCK_BITS-1:0]  data_q,
  output logic [BLOCK_BYTES-1:0] mask_q
);
  logic [BLK_W-1:0]       blk_n;
  logic [BLOCK_BITS-1:0]  data_n;
  logic [BLOCK_BYTES-1:0] mask_n;
  logic                   wr_en;

  always_comb begin
    wr_en = load | merge;
    blk_n = load ? blk_in : blk_q;
    if (load)       mask_n = wide_mask;
    else if (merge) mask_n = mask_q | wide_mask;
    else            mask_n = mask_q;
    for (int b = 0; b < BLOCK_BYTES; b++) begin
      if (load)
        data_n[b*8 +: 8] = wide_mask[b] ? wide_data[b*8 +: 8] : 8'h00;
      else if (merge && wide_mask[b])
        data_n[b*8 +: 8] = wide_data[b*8 +: 8];
      else
        data_n[b*8 +: 8] = data_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      blk_q  <= blk_n;
      data_q <= data_n;
      mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/merge_write_buffer.sv
`timescale 1ns/1ps
module merge_write_buffer #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int N_ENT       = 4,
  localparam int WORD_BITS  = WORD_BYTES * 8,
  localparam int BLOCK_BITS = BLOCK_BYTES * 8,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int LANE_W     = $clog2(WORD_BYTES),
  localparam int WSEL_W     = OFF_W - LANE_W,
  localparam int N_WORDS    = BLOCK_BYTES / WORD_BYTES,
  localparam int BLK_W      = ADDR_W - OFF_W,
  localparam int PTR_W      = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   st_valid,
  output logic                   st_ready,
  input  logic [ADDR_W-1:0]      st_addr,
  input  logic [WORD_BITS-1:0]   st_wdata,
  input  logic [WORD_BYTES-1:0]  st_be,
  output logic                   dr_valid,
  input  logic                   dr_ack,
  output logic [BLK_W-1:0]       dr_blk_addr,
  output logic [BLOCK_BITS-1:0]  dr_data,
  output logic [BLOCK_BYTES-1:0] dr_byte_mask,
  output logic                   dr_full
);
  import wb_pkg::*;

  logic [PTR_W-1:0]                 head_idx, tail_idx;
  logic [N_ENT-1:0]                 occ, head_oh, elig, hit, load_v, merge_v;
  logic                             full, empty, hit_any, drain_go, push;
  logic [N_ENT-1:0][BLK_W-1:0]      tag_arr;
  logic [N_ENT-1:0][BLOCK_BITS-1:0] data_arr;
  logic [N_ENT-1:0][BLOCK_BYTES-1:0] mask_arr;
  logic [BLK_W-1:0]                 st_blk;
  logic [WSEL_W-1:0]                st_wsel;
  logic [BLOCK_BITS-1:0]            wide_data;
  logic [BLOCK_BYTES-1:0]           wide_mask;
  logic                             unused_lane_bits;
  st_act_e                          act;

  // Store address split: block number, word within block, ignored lane bits.
  assign st_blk           = st_addr[ADDR_W-1:OFF_W];
  assign st_wsel          = st_addr[OFF_W-1:LANE_W];
  assign unused_lane_bits = ^st_addr[LANE_W-1:0];

  // Steer the store word onto its position within a block.
  for (genvar w = 0; w < N_WORDS; w++) begin : g_place
    assign wide_mask[w*WORD_BYTES +: WORD_BYTES] =
      (st_wsel == WSEL_W'(w)) ? st_be : '0;
    assign wide_data[w*WORD_BITS +: WORD_BITS] =
      (st_wsel == WSEL_W'(w)) ? st_wdata : '0;
  end

  wb_order #(.N_ENT(N_ENT)) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (drain_go),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  // The oldest slot is on the drain port and closed to merges.
  for (genvar i = 0; i < N_ENT; i++) begin : g_head
    assign head_oh[i] = (head_idx == PTR_W'(i));
  end
  assign elig = occ & ~head_oh;

  wb_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_match (
    .key     (st_blk),
    .tags    (tag_arr),
    .elig    (elig),
    .hit     (hit),
    .hit_any (hit_any)
  );

  assign dr_valid = ~empty;
  assign drain_go = dr_valid & dr_ack;
  assign st_ready = hit_any | ~full | drain_go;

  always_comb begin
    act = ACT_IDLE;
    if (st_valid && st_ready) act = hit_any ? ACT_MERGE : ACT_ALLOC;
  end
  assign push = (act == ACT_ALLOC);

  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    assign load_v[i]  = push && (tail_idx == PTR_W'(i));
    assign merge_v[i] = (act == ACT_MERGE) && hit[i];

    wb_entry #(.BLK_W(BLK_W), .BLOCK_BYTES(BLOCK_BYTES)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_v[i]),
      .merge     (merge_v[i]),
      .blk_in    (st_blk),
      .wide_data (wide_data),
      .wide_mask (wide_mask),
      .blk_q     (tag_arr[i]),
      .data_q    (data_arr[i]),
      .mask_q    (mask_arr[i])
    );
  end

  assign dr_blk_addr  = tag_arr[head_idx];
  assign dr_data      = data_arr[head_idx];
  assign dr_byte_mask = mask_arr[head_idx];
  assign dr_full      = dr_valid & (&mask_arr[head_idx]);
endmodule

// File: rtl/wb_checker.sv
`timescale 1ns/1ps
module wb_checker #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - OFF_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     st_valid,
  input logic                     st_ready,
  input logic                     dr_valid,
  input logic                     dr_ack,
  input logic [BLK_W-1:0]         dr_blk_addr,
  input logic [BLOCK_BYTES*8-1:0] dr_data,
  input logic [BLOCK_BYTES-1:0]   dr_byte_mask
);
  p_empty_accepts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_valid |-> st_ready);

  p_alloc_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !dr_valid) |=> dr_valid);

  p_stall_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> (dr_valid && !dr_ack));

  p_slot_reuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && dr_ack) |-> st_ready);

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ack) |=> (dr_valid && $stable(dr_blk_addr)
                               && $stable(dr_byte_mask) && $stable(dr_data)));
endmodule

bind merge_write_buffer wb_checker #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .dr_valid     (dr_valid),
  .dr_ack       (dr_ack),
  .dr_blk_addr  (dr_blk_addr),
  .dr_data      (dr_data),
  .dr_byte_mask (dr_byte_mask)
);

// File: tb/merge_write_buffer_tb.sv
`timescale 1ns/1ps
module merge_write_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready, dr_valid, dr_ack, dr_full;
  logic [31:0]  st_addr, st_wdata;
  logic [3:0]   st_be;
  logic [26:0]  dr_blk_addr;
  logic [255:0] dr_data;
  logic [31:0]  dr_byte_mask;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  merge_write_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_wdata(st_wdata), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ack(dr_ack), .dr_blk_addr(dr_blk_addr),
    .dr_data(dr_data), .dr_byte_mask(dr_byte_mask), .dr_full(dr_full)
  );

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Fold one store word into an expected block, byte by byte.
  task automatic fold(inout logic [255:0] d, inout logic [31:0] m,
                      input logic [31:0] wd, input logic [3:0] be, input int w);
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        d[(w*4+l)*8 +: 8] = wd[l*8 +: 8];
        m[w*4+l] = 1'b1;
      end
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1'b1; st_addr = a; st_wdata = d; st_be = be;
    @(negedge clk);
    st_valid = 1'b0; st_be = '0;
  endtask

  task automatic drain_one();
    dr_ack = 1'b1;
    @(negedge clk);
    dr_ack = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [26:0] blk,
                             input logic [255:0] d, input logic [31:0] m);
    chk(req, "dr_valid", 256'(dr_valid), 256'(1'b1));
    chk(req, "dr_blk_addr", 256'(dr_blk_addr), 256'(blk));
    chk(req, "dr_byte_mask", 256'(dr_byte_mask), 256'(m));
    chk(req, "dr_data", dr_data, d);
    chk("R8", "dr_full", 256'(dr_full), 256'(&m));
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] ed, ed2;
    logic [31:0]  em, em2;
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_wdata = '0; st_be = '0; dr_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset and ready
    chk("R1", "dr_valid", 256'(dr_valid), 256'(1'b0));
    chk("R1", "st_ready", 256'(st_ready), 256'(1'b1));

    // R2/R8/R10: every word position against every nonzero enable pattern
    for (int w = 0; w < 8; w++) begin
      for (int be = 1; be < 16; be++) begin
        logic [31:0] a, d;
        a = 32'h4000_0000 + 32'((w * 15 + be) * 32) + 32'(w * 4) + 32'(be & 3);
        d = 32'hA500_0000 ^ (32'(w * 16 + be) * 32'h0101_0101);
        ed = '0; em = '0;
        fold(ed, em, d, 4'(be), w);
        put(a, d, 4'(be));
        expect_head("R2", a[31:5], ed, em);
        drain_one();
        chk("R10", "dr_valid after drain", 256'(dr_valid), 256'(1'b0));
      end
    end

    // R3/R4/R7/R8: stitch block B to full while A is locked at the head
    ed = '0; em = '0;
    put(32'h0000_1000 + 12, 32'h1111_2222, 4'hF);          // A word 3
    fold(ed, em, 32'h1111_2222, 4'hF, 3);
    ed2 = '0; em2 = '0;
    for (int w = 0; w < 8; w++) begin
      put(32'h0000_2000 + 32'(w * 4), 32'hC0DE_0000 + 32'(w), 4'hF);
      fold(ed2, em2, 32'hC0DE_0000 + 32'(w), 4'hF, w);
    end
    put(32'h0000_2000 + 8, 32'h0000_BEEF, 4'h3);            // overwrite lanes 0,1 of word 2
    fold(ed2, em2, 32'h0000_BEEF, 4'h3, 2);
    put(32'h0000_1000 + 20, 32'h0000_0077, 4'h1);          // store to locked A: new slot
    expect_head("R4", 27'h0000_1000 >> 5, ed, em);         // A unchanged by it
    drain_one();
    expect_head("R3", 27'h0000_2000 >> 5, ed2, em2);       // B complete, merged
    chk("R8", "dr_full stitched", 256'(dr_full), 256'(1'b1));
    drain_one();
    ed = '0; em = '0;
    fold(ed, em, 32'h0000_0077, 4'h1, 5);
    expect_head("R7", 27'h0000_1000 >> 5, ed, em);         // second A slot last
    drain_one();
    chk("R10", "dr_valid empty", 256'(dr_valid), 256'(1'b0));

    // R5/R6/R9: fill all slots, stall, merge while full, reuse on drain
    for (int k = 0; k < 4; k++)
      put(32'h0001_0000 + 32'(k * 32), 32'h5000_0000 + 32'(k), 4'hF);
    st_valid = 1'b1; st_addr = 32'h0002_0000; st_wdata = 32'hEEEE_EEEE; st_be = 4'hF;
    #1 chk("R5", "st_ready full", 256'(st_ready), 256'(1'b0));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1 chk("R5", "st_ready held", 256'(st_ready), 256'(1'b0));
      chk("R9", "head held", 256'(dr_blk_addr), 256'(27'h0001_0000 >> 5));
    end
    st_addr = 32'h0001_0000 + 4;                            // head block
    #1 chk("R4", "st_ready head match", 256'(st_ready), 256'(1'b0));
    st_addr = 32'h0001_0040 + 4; st_wdata = 32'h6666_7777; // third slot, word 1
    #1 chk("R3", "st_ready merge while full", 256'(st_ready), 256'(1'b1));
    @(negedge clk);
    st_valid = 1'b0;
    dr_ack = 1'b1; st_valid = 1'b1; st_addr = 32'h0002_0000; st_wdata = 32'hEEEE_EEEE;
    #1 chk("R6", "st_ready on drain", 256'(st_ready), 256'(1'b1));
    @(negedge clk);
    dr_ack = 1'b0; st_valid = 1'b0;
    for (int k = 1; k < 4; k++) begin
      ed = '0; em = '0;
      fold(ed, em, 32'h5000_0000 + 32'(k), 4'hF, 0);
      if (k == 2) fold(ed, em, 32'h6666_7777, 4'hF, 1);
      expect_head("R7", 27'((32'h0001_0000 + 32'(k * 32)) >> 5), ed, em);
      drain_one();
    end
    ed = '0; em = '0;
    fold(ed, em, 32'hEEEE_EEEE, 4'hF, 0);
    expect_head("R6", 27'h0002_0000 >> 5, ed, em);
    drain_one();
    chk("R10", "dr_valid final", 256'(dr_valid), 256'(1'b0));
    chk("R1", "st_ready final", 256'(st_ready), 256'(1'b1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule